// File: doc/BRIEF.md
# AC-link Transmit Channel Serializer

This block is a single transmit channel of an AC'97-style audio link controller. Software places one PCM sample at a time into a holding register. When an output slot that belongs to this channel begins, the block formats the held sample and loads it into a 20-bit shift register. Formatting means an optional byte reversal, then extraction of 10, 16, 18 or 20 bits, then left-justification with zero padding. The slot is then shifted out on the serial data line, most significant bit first.

A ready flag, mirrored on a level interrupt, tells software when the holding register can accept the next sample. Frame timing comes from outside the block. A neighbouring frame sequencer pulses `slot_start` on the bit clock where a slot begins and gives the slot number alongside it: 0 is the tag slot and 1 to 12 are the data slots. A slot-assignment mask chooses which data slots carry this channel.

Top module: `actx_channel`

## Requirements
- R1: After reset, `ready` and `irq` are high and `sdata` is low.
- R2: A write (`wr_valid` high at a clock edge) makes `ready` and `irq` low from the next cycle on. They stay low until the held sample is transferred.
- R3: A held sample is transferred at a `slot_start` edge when three conditions hold: the slot is assigned, `glob_en` is high and `chan_en` is high. If there is no write on that same edge, `ready` is high from the next cycle. `irq` always equals `ready`.
- R4: A loaded slot word appears on `sdata` MSB first. Bit 19 is driven in the cycle after the `slot_start` edge, and each following cycle carries the next lower bit. Once the 20 bits have been sent, `sdata` stays low until the next load.
- R5: The size code `size_sel` selects the sample width: 0 gives 10 bits, 1 gives 16, 2 gives 18 and 3 gives 20. The low-order bits of the word are placed at the top of the 20-bit slot, and the slot bits below them are zero. The size is sampled at the transfer edge.
- R6: With `little_end` high, the four bytes of the 32-bit word are reversed before the width is extracted (byte 0 becomes byte 3). With `little_end` low, the word is used unchanged.
- R7: Bit i of `slot_map` assigns data slot i+1. Slot 0, the tag slot, never carries channel data. An unassigned slot sends twenty zeros.
- R8: If an assigned slot begins while the holding register is empty, the slot carries zeros and `ready` stays high.
- R9: If `glob_en` or `chan_en` is low, every slot carries zeros, the held sample is kept, and `ready` does not change.
- R10: If a write arrives on the same edge as a transfer, the old sample is sent, the new sample is held, and `ready` stays low.
- R11: A write while the holding register is already full replaces the pending sample, and only the latest sample is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Controller-wide transmit enable |
| chan_en | input | 1 | Enable for this channel |
| size_sel | input | 2 | Sample width code (0:10, 1:16, 2:18, 3:20 bits) |
| little_end | input | 1 | Byte-reverse the written word before extraction |
| slot_map | input | 12 | Data slot assignment, bit i for slot i+1 |
| slot_start | input | 1 | First bit clock of a slot |
| slot_num | input | 4 | Number of the slot that starts (0 = tag) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Sample word written by software |
| ready | output | 1 | Holding register can take a new sample |
| irq | output | 1 | Level interrupt, high while ready |
| sdata | output | 1 | Serial slot data, MSB first |

## Verification
The bench drives full 256-clock frames and checks every bit clock against a behavioural model built from a bit queue. Words with distinct bit patterns are sent under each size code and under both byte orders. A wrong extraction width, a missing swap or a wrong padding therefore shows up as a misplaced bit rather than as a coincidental match. Different slot masks (a single slot, the first and last slot, adjacent slots) separate a mask-decoding error from a shifting error. Writes are placed before a frame, in the middle of a frame, and exactly on a transfer edge, which tells apart the overwrite, concurrent-write and empty-slot cases. Frames run with each enable low in turn, to show that the held sample survives and is sent once both enables are high again.

// File: rtl/actx_pkg.sv
// Package: actx_pkg
// Shared constants and the sample-size encoding for the AC-link transmit
// channel. Assumes the link's 20-bit data slot and a 32-bit software word.
package actx_pkg;
    localparam int SLOT_W         = 20;
    localparam int WORD_W         = 32;
    localparam int NUM_DATA_SLOTS = 12;

    typedef enum logic [1:0] {
        SZ_10 = 2'd0,
        SZ_16 = 2'd1,
        SZ_18 = 2'd2,
        SZ_20 = 2'd3
    } size_e;
endpackage

// File: rtl/actx_fmt.sv
// Module: actx_fmt
// Turns a software word into a 20-bit slot word: it optionally reverses the
// byte order, keeps the low 10/16/18/20 bits and left-justifies them with
// zero fill. Purely combinational. Assumes WORD_W is a multiple of 8 and
// SLOT_W is 20.
module actx_fmt
    import actx_pkg::*;
#(
    parameter int FW_WORD = WORD_W,
    parameter int FW_SLOT = SLOT_W
) (
    input  logic [FW_WORD-1:0] word,
    input  logic               little_end,
    input  logic [1:0]         size_sel,
    output logic [FW_SLOT-1:0] slot_word
);
    localparam int NBYTES = FW_WORD / 8;

    logic [FW_WORD-1:0] swapped;
    logic [FW_WORD-1:0] ordered;
    logic               unused_hi;

    // Byte reversal network, one lane per byte.
    for (genvar g = 0; g < NBYTES; g++) begin : g_swap
        assign swapped[g*8 +: 8] = word[(NBYTES-1-g)*8 +: 8];
    end

    assign ordered   = little_end ? swapped : word;
    assign unused_hi = ^ordered[FW_WORD-1:FW_SLOT];

    // Width extraction and left justification.
    always_comb begin
        case (size_e'(size_sel))
            SZ_10:   slot_word = {ordered[9:0],  {(FW_SLOT-10){1'b0}}};
            SZ_16:   slot_word = {ordered[15:0], {(FW_SLOT-16){1'b0}}};
            SZ_18:   slot_word = {ordered[17:0], {(FW_SLOT-18){1'b0}}};
            default: slot_word = ordered[FW_SLOT-1:0];
        endcase
    end
endmodule

// File: rtl/actx_hold.sv
// Module: actx_hold
// Holding register with a full flag. A write always stores the word and
// marks it full. A transfer request empties it only if it was full and no
// write lands on the same edge. Assumes take_req is a single-cycle pulse.
module actx_hold #(
    parameter int HW_WORD = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [HW_WORD-1:0] wr_data,
    input  logic               take_req,
    output logic [HW_WORD-1:0] hold_word,
    output logic               full,
    output logic               take
);
    // A transfer happens only when something is held.
    assign take = take_req & full;

    // Full flag: set by a write, cleared by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (wr_valid) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Data store: captures each written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
        end else if (wr_valid) begin
            hold_word <= wr_data;
        end
    end
endmodule

// File: rtl/actx_shift.sv
// Module: actx_shift
// Slot shifter. It loads a slot word at each slot start, whether that word
// is real data or zeros, then shifts left and fills with zeros, so the
// serial output is the MSB of the register. Assumes at least SLOT_W clocks
// between loads.
module actx_shift #(
    parameter int SW_SLOT = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SW_SLOT-1:0] load_word,
    output logic               sdata
);
    logic [SW_SLOT-1:0] sh;

    // Load at slot start, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_word;
        end else begin
            sh <= {sh[SW_SLOT-2:0], 1'b0};
        end
    end

    assign sdata = sh[SW_SLOT-1];
endmodule

// File: rtl/actx_channel.sv
// Module: actx_channel (top)
// One transmit channel of an AC-link controller. It decodes whether the
// starting slot belongs to this channel, moves the held sample into the
// shifter through the formatter, and reports readiness. Assumes an external
// frame sequencer drives slot_start/slot_num on the bit clock.
module actx_channel
    import actx_pkg::*;
#(
    parameter int CW_WORD  = WORD_W,
    parameter int CW_SLOT  = SLOT_W,
    parameter int CW_NSLOT = NUM_DATA_SLOTS,
    localparam int IDX_W   = $clog2(CW_NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                glob_en,
    input  logic                chan_en,
    input  logic [1:0]          size_sel,
    input  logic                little_end,
    input  logic [CW_NSLOT-1:0] slot_map,
    input  logic                slot_start,
    input  logic [IDX_W-1:0]    slot_num,
    input  logic                wr_valid,
    input  logic [CW_WORD-1:0]  wr_data,
    output logic                ready,
    output logic                irq,
    output logic                sdata
);
    logic [CW_NSLOT-1:0] hit;
    logic                assigned;
    logic                active;
    logic                take_req;
    logic                take;
    logic                full;
    logic [CW_WORD-1:0]  hold_word;
    logic [CW_SLOT-1:0]  fmt_word;
    logic [CW_SLOT-1:0]  load_word;

    // Slot decode: data slot g+1 is claimed by slot_map bit g.
    for (genvar g = 0; g < CW_NSLOT; g++) begin : g_dec
        assign hit[g] = slot_map[g] && (slot_num == IDX_W'(g + 1));
    end

    assign assigned = |hit;
    assign active   = glob_en & chan_en;
    assign take_req = slot_start & assigned & active;

    actx_hold #(.HW_WORD(CW_WORD)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .take_req  (take_req),
        .hold_word (hold_word),
        .full      (full),
        .take      (take)
    );

    actx_fmt #(.FW_WORD(CW_WORD), .FW_SLOT(CW_SLOT)) u_fmt (
        .word       (hold_word),
        .little_end (little_end),
        .size_sel   (size_sel),
        .slot_word  (fmt_word)
    );

    // Zeros go out unless a real sample is being transferred.
    assign load_word = take ? fmt_word : '0;

    actx_shift #(.SW_SLOT(CW_SLOT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_start),
        .load_word (load_word),
        .sdata     (sdata)
    );

    assign ready = ~full;
    assign irq   = ~full;
endmodule

// File: rtl/actx_channel_chk.sv
// Module: actx_channel_chk
// Protocol checker bound to actx_channel. It watches the handshake and the
// serial line across clock edges. Assumes the synchronous active-low reset.
module actx_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic slot_start,
    input logic assigned,
    input logic active,
    input logic take,
    input logic ready,
    input logic sdata
);
    // R2
    wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !ready);

    // R2
    pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !take && !wr_valid) |=> !ready);

    // R3
    take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_valid) |=> ready);

    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_valid) |=> ready);

    // R7
    unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !assigned) |=> !sdata);

    // R9
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !active) |=> !sdata);
endmodule

bind actx_channel actx_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .slot_start (slot_start),
    .assigned   (assigned),
    .active     (active),
    .take       (take),
    .ready      (ready),
    .sdata      (sdata)
);

// File: tb/tb_actx_channel.sv
// Bench for actx_channel: a behavioural model (bit queue plus a full flag)
// predicts ready, irq and sdata, and all three are compared on every clock.
module tb_actx_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glob_en = 1'b0;
    logic        chan_en = 1'b0;
    logic [1:0]  size_sel = 2'd3;
    logic        little_end = 1'b0;
    logic [11:0] slot_map = '0;
    logic        slot_start = 1'b0;
    logic [3:0]  slot_num = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ready, irq, sdata;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit          m_full = 1'b0;
    logic [31:0] m_hold = '0;
    bit          q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    actx_channel dut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .chan_en(chan_en),
        .size_sel(size_sel), .little_end(little_end), .slot_map(slot_map),
        .slot_start(slot_start), .slot_num(slot_num), .wr_valid(wr_valid),
        .wr_data(wr_data), .ready(ready), .irq(irq), .sdata(sdata)
    );

    function automatic logic [19:0] m_fmt(logic [31:0] w);
        logic [31:0] x;
        logic [19:0] r;
        int wid;
        x = w;
        if (little_end) x = {w[7:0], w[15:8], w[23:16], w[31:24]};
        case (size_sel)
            2'd0: wid = 10;
            2'd1: wid = 16;
            2'd2: wid = 18;
            default: wid = 20;
        endcase
        r = '0;
        for (int i = 0; i < wid; i++) r[19-i] = x[wid-1-i];
        return r;
    endfunction

    function automatic bit m_assigned();
        if (slot_num < 1 || slot_num > 12) return 1'b0;
        return slot_map[slot_num - 1];
    endfunction

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t",
                     cur_req, what, act, exp, $time);
        end
    endtask

    // Predict the effect of the coming edge, apply it, then compare.
    task automatic tick();
        bit go;
        logic [19:0] sw;
        bit exp_sd;
        if (!rst_n) begin
            m_full = 1'b0;
            q.delete();
        end else begin
            go = slot_start && m_assigned() && glob_en && chan_en;
            if (slot_start) begin
                q.delete();
                if (go && m_full) begin
                    sw = m_fmt(m_hold);
                    for (int i = 19; i >= 0; i--) q.push_back(sw[i]);
                    m_full = 1'b0;
                end
            end else if (q.size() > 0) begin
                void'(q.pop_front());
            end
            if (wr_valid) begin
                m_full = 1'b1;
                m_hold = wr_data;
            end
        end
        @(posedge clk);
        #1;
        exp_sd = (q.size() > 0) ? q[0] : 1'b0;
        chk("ready", ready, !m_full);
        chk("irq", irq, !m_full);
        chk("sdata", sdata, exp_sd);
    endtask

    task automatic write_word(logic [31:0] w);
        wr_valid = 1'b1;
        wr_data  = w;
        tick();
        wr_valid = 1'b0;
    endtask

    // One frame: a 16-clock tag slot, then twelve 20-clock data slots.
    // An optional write lands at (ws, wb).
    task automatic run_frame(int ws, int wb, logic [31:0] w);
        for (int s = 0; s <= 12; s++) begin
            for (int b = 0; b < ((s == 0) ? 16 : 20); b++) begin
                slot_start = (b == 0);
                slot_num   = 4'(s);
                wr_valid   = (s == ws && b == wb);
                wr_data    = w;
                tick();
            end
        end
        slot_start = 1'b0;
        wr_valid   = 1'b0;
        slot_num   = '0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        // R2, R3, R4: 20-bit big-endian sample in slot 3
        glob_en = 1'b1; chan_en = 1'b1;
        slot_map = 12'b0000_0000_0100;
        size_sel = 2'd3; little_end = 1'b0;
        cur_req = "R2";
        write_word(32'h000A_BCDE);
        repeat (3) tick();
        cur_req = "R4";
        run_frame(-1, 0, '0);

        // R5: the narrower widths
        cur_req = "R5";
        for (int sz = 0; sz < 3; sz++) begin
            size_sel = 2'(sz);
            write_word(32'hFFF5_A6AB);
            run_frame(-1, 0, '0);
        end

        // R6: little-endian byte reversal at 20 and 16 bits
        cur_req = "R6";
        little_end = 1'b1; size_sel = 2'd3;
        write_word(32'h1122_3344);
        run_frame(-1, 0, '0);
        size_sel = 2'd1;
        write_word(32'hC3A5_0F96);
        run_frame(-1, 0, '0);
        little_end = 1'b0; size_sel = 2'd3;

        // R7 and R3: first and last slot, second sample written mid-frame
        cur_req = "R7";
        slot_map = 12'b1000_0000_0001;
        write_word(32'h0005_5AA3);
        run_frame(5, 3, 32'h000F_0C1E);

        // R8: assigned slots but nothing written
        cur_req = "R8";
        run_frame(-1, 0, '0);

        // R9: each enable low in turn, then both high
        cur_req = "R9";
        slot_map = 12'b0000_0000_0100;
        glob_en = 1'b0;
        write_word(32'h0009_9876);
        run_frame(-1, 0, '0);
        glob_en = 1'b1; chan_en = 1'b0;
        run_frame(-1, 0, '0);
        chan_en = 1'b1;
        run_frame(-1, 0, '0);

        // R10: write on the same edge as the slot 2 transfer
        cur_req = "R10";
        slot_map = 12'b0000_0000_0110;
        write_word(32'h000B_1357);
        run_frame(2, 0, 32'h0006_2468);

        // R11: overwrite a pending sample
        cur_req = "R11";
        slot_map = 12'b0000_0000_0100;
        write_word(32'h0001_1111);
        write_word(32'h000E_EE0D);
        run_frame(-1, 0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule